// File: doc/BRIEF.md
# Phase Counter with Serial Readout

This block measures the phase offset between an external reference pulse and a local oscillator. It counts oscillator clock cycles. A prescaler divides the oscillator down to a local tick, and the divide ratio is picked by a rate pin: the short ratio suits the lower oscillator frequency and the long ratio (twice the short one by default) suits the doubled frequency. Each local tick opens a measurement window. The next synchronised rising edge of the reference pulse closes it. The number of clock edges in the window is the phase count for that measurement.

Phase counts are summed over a batch. The batch size is a power of two picked by select pins. When a batch completes, the sum is copied into a shift register and the interrupt line rises in the same clock. Counting goes on while the host reads. The host clocks the word out on one serial data line using its own serial clock, most significant bit first. The interrupt falls after the last bit has left. Both the reference pulse and the serial clock are asynchronous to the oscillator and pass through two-flop synchronisers. All counts use a parameter width of 16, 20 or 24 bits. Every count saturates at all-ones and never wraps, so a missing reference pulse reads back as full scale.

Top module: `phase_serial_counter`

## Requirements
- R1: While reset is asserted and right after it, `irq` is 0 and `sdo` is 0.
- R2: The local tick occurs on every `DIV_LO`-th clock edge when `rate_sel`=0 and on every `DIV_HI`-th edge when `rate_sel`=1. After reset with a constant rate, the first tick falls on edge `DIV_LO` (or `DIV_HI`), counting the first edge after reset release as edge 1.
- R3: A tick opens a measurement window only when no window is open. Ticks that arrive while a window is open are ignored, so a result may exceed the divide ratio.
- R4: The reference rising edge is acted on at clock edge k+2, where k is the first edge that samples `ref_in` high after it was sampled low. That edge closes the open window, and the result equals the number of edges from the opening edge to the closing edge. A reference edge with no open window is ignored.
- R5: A window result saturates at 2^CW−1 when no reference edge arrives. The batch sum also saturates at 2^CW−1 and does not wrap.
- R6: One batch is 2^`meas_sel` results. On the clock edge that closes the last window of a batch, the batch sum loads the shift register and `irq` rises. The sum then restarts from zero.
- R7: A batch that completes while `irq` is high is discarded, and the word being read out is unchanged.
- R8: `sdo` always shows the shift register MSB. Each serial clock rising edge moves to the next bit, MSB first, with the same k+2 synchronisation as R4. After CW edges `irq` falls and `sdo` reads 0.
- R9: Serial clock rising edges while `irq` is low are ignored. `sdo` stays 0 and the next readout is whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, counting time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference pulse |
| rate_sel | input | 1 | Prescale select: 0 gives `DIV_LO`, 1 gives `DIV_HI` |
| meas_sel | input | MSEL_W | Batch size exponent, 2^meas_sel results per interrupt |
| sclk | input | 1 | Host serial clock, asynchronous |
| irq | output | 1 | Result-ready interrupt to the host |
| sdo | output | 1 | Serial data, MSB first |

## Verification
A single window closed by a reference edge at a known offset from reset tells apart the two prescale ratios and shows that an early reference edge, arriving before any window opens, is dropped. A window that spans an extra tick separates ignored ticks from a restarted count. Batches of two and four windows with different offsets, and a run with the reference held low for more than 2^16 cycles, cover summing and saturation. Back-to-back batches with no readout, and stray serial clocks while idle, cover the discard rule and the idle rule.

// File: rtl/phc_pkg.sv
package phc_pkg;
   typedef enum logic {
      RATE_SLOW = 1'b0,
      RATE_FAST = 1'b1
   } rate_e;

   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;
endpackage

// File: rtl/phc_sync_edge.sv
module phc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   if (STAGES < 1) begin : g_bad_stages
      $error("phc_sync_edge: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= din;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], din};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/phc_prescaler.sv
module phc_prescaler
   import phc_pkg::*;
#(
   parameter int DIV_LO = 40,
   parameter int DIV_HI = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_sel,
   output logic tick
);
   localparam int PCW = $clog2(DIV_HI);

   logic [PCW-1:0] pc;
   logic [PCW-1:0] limit;

   if (DIV_LO < 2 || DIV_HI <= DIV_LO) begin : g_bad_div
      $error("phc_prescaler: need 2 <= DIV_LO < DIV_HI");
   end

   assign limit = (rate_e'(rate_sel) == RATE_FAST) ? PCW'(DIV_HI - 1) : PCW'(DIV_LO - 1);
   assign tick  = (pc >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= '0;
      else if (tick) pc <= '0;
      else           pc <= pc + 1'b1;
   end

   // R2
   pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= PCW'(DIV_HI - 1));

   // R2
   tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pc == '0));
endmodule

// File: rtl/phc_window.sv
module phc_window
   import phc_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ref_rise,
   output logic          done,
   output logic [CW-1:0] result
);
   localparam logic [CW-1:0] FULL = '1;

   win_state_e    state;
   logic [CW-1:0] cnt;

   function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
      return (v == FULL) ? v : v + 1'b1;
   endfunction

   assign done   = (state == WIN_OPEN) && ref_rise;
   assign result = sat_inc(cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WIN_IDLE;
         cnt   <= '0;
      end else if (state == WIN_IDLE) begin
         if (tick) begin
            state <= WIN_OPEN;
            cnt   <= '0;
         end
      end else if (ref_rise) begin
         state <= WIN_IDLE;
         cnt   <= '0;
      end else begin
         cnt <= sat_inc(cnt);
      end
   end

   // R3
   open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WIN_OPEN && !ref_rise) |=> (state == WIN_OPEN));

   // R5
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WIN_OPEN && !ref_rise && cnt == FULL) |=> (cnt == FULL));
endmodule

// File: rtl/phc_batch.sv
module phc_batch #(
   parameter int CW     = 16,
   parameter int MSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [CW-1:0]     result,
   input  logic [MSEL_W-1:0] meas_sel,
   output logic              load,
   output logic [CW-1:0]     load_val
);
   localparam int NSEL  = 1 << MSEL_W;
   localparam int MAX_M = 1 << (NSEL - 1);
   localparam int MCW   = $clog2(MAX_M) + 1;

   logic [CW-1:0]  acc;
   logic [MCW-1:0] mcount;
   logic [MCW-1:0] mc_next;
   logic [MCW-1:0] m_target;
   logic           last_one;

   function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
      logic [CW:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[CW] ? {CW{1'b1}} : s[CW-1:0];
   endfunction

   assign mc_next  = mcount + 1'b1;
   assign m_target = MCW'(1) << meas_sel;
   assign last_one = (mc_next >= m_target);
   assign load_val = sat_add(acc, result);
   assign load     = done && last_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         mcount <= '0;
      end else if (done) begin
         if (last_one) begin
            acc    <= '0;
            mcount <= '0;
         end else begin
            acc    <= load_val;
            mcount <= mc_next;
         end
      end
   end

   // R6
   mcount_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mcount < MCW'(MAX_M));

   // R6
   restart_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mcount == '0 && acc == '0));
endmodule

// File: rtl/phc_shifter.sv
module phc_shifter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          sclk_rise,
   output logic          irq,
   output logic          sdo
);
   localparam int BW = $clog2(CW + 1);
   localparam logic [BW-1:0] LASTB = BW'(CW - 1);

   logic [CW-1:0] shreg;
   logic [BW-1:0] nbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         nbits <= '0;
         irq   <= 1'b0;
      end else if (irq) begin
         if (sclk_rise) begin
            shreg <= {shreg[CW-2:0], 1'b0};
            nbits <= nbits + 1'b1;
            if (nbits == LASTB) irq <= 1'b0;
         end
      end else if (load) begin
         shreg <= load_val;
         nbits <= '0;
         irq   <= 1'b1;
      end
   end

   assign sdo = shreg[CW-1];

   // R8
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(nbits) == LASTB && $past(sclk_rise)));

   // R6
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (nbits == '0 && $past(load)));

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && load && !sclk_rise) |=> ($stable(shreg) && irq));

   // R9
   idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !load) |=> ($stable(shreg) && !irq));
endmodule

// File: rtl/phase_serial_counter.sv
module phase_serial_counter #(
   parameter int CW          = 16,
   parameter int DIV_LO      = 40,
   parameter int DIV_HI      = 80,
   parameter int MSEL_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_in,
   input  logic              rate_sel,
   input  logic [MSEL_W-1:0] meas_sel,
   input  logic              sclk,
   output logic              irq,
   output logic              sdo
);
   if (CW != 16 && CW != 20 && CW != 24) begin : g_bad_cw
      $error("phase_serial_counter: CW must be 16, 20 or 24");
   end
   if (MSEL_W < 1 || MSEL_W > 3) begin : g_bad_msel
      $error("phase_serial_counter: MSEL_W must be 1 to 3");
   end

   logic          tick;
   logic          ref_rise;
   logic          sclk_rise;
   logic          done;
   logic [CW-1:0] result;
   logic          load;
   logic [CW-1:0] load_val;

   phc_sync_edge #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk(clk), .rst_n(rst_n), .din(ref_in), .rise(ref_rise));

   phc_sync_edge #(.STAGES(SYNC_STAGES)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise));

   phc_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_presc (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tick(tick));

   phc_window #(.CW(CW)) u_win (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ref_rise(ref_rise),
      .done(done), .result(result));

   phc_batch #(.CW(CW), .MSEL_W(MSEL_W)) u_batch (
      .clk(clk), .rst_n(rst_n), .done(done), .result(result),
      .meas_sel(meas_sel), .load(load), .load_val(load_val));

   phc_shifter #(.CW(CW)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .sclk_rise(sclk_rise), .irq(irq), .sdo(sdo));

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq && !sdo));
endmodule

// File: tb/phase_serial_counter_test.sv
module phase_serial_counter_test;
   localparam int CLK_PERIOD = 10;
   localparam int CW     = 16;
   localparam int DIV_LO = 40;
   localparam int DIV_HI = 80;
   localparam int MAXV   = (1 << CW) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       rate_sel = 1'b0;
   logic [1:0] meas_sel = 2'd0;
   logic       sclk = 1'b0;
   logic       irq;
   logic       sdo;

   int checks = 0;
   int failures = 0;

   phase_serial_counter uut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rate_sel(rate_sel),
      .meas_sel(meas_sel), .sclk(sclk), .irq(irq), .sdo(sdo));

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // Behavioural reference, advanced once per rising edge
   int cyc, m_pc, m_cnt, m_acc, m_mc, m_sh, m_bits, open_cyc;
   int m_div, m_res, m_sum;
   bit m_open, m_irq, m_tick, m_rev, m_sev, m_done, m_irq_pre;
   bit rq0, rq1, rq2, sq0, sq1, sq2;

   always @(posedge clk) begin
      if (!rst_n) begin
         cyc = 0; m_pc = 0; m_cnt = 0; m_acc = 0; m_mc = 0; m_sh = 0;
         m_bits = 0; m_open = 0; m_irq = 0; open_cyc = 0;
         rq0 = 0; rq1 = 0; rq2 = 0; sq0 = 0; sq1 = 0; sq2 = 0;
      end else begin
         cyc++;
         m_div  = rate_sel ? DIV_HI : DIV_LO;
         m_tick = (m_pc >= m_div - 1);
         m_rev  = rq1 && !rq2;
         m_sev  = sq1 && !sq2;
         m_pc   = m_tick ? 0 : m_pc + 1;
         m_done = 0;
         if (m_open) begin
            if (m_rev) begin
               m_res = (m_cnt + 1 > MAXV) ? MAXV : m_cnt + 1;
               m_open = 0; m_cnt = 0; m_done = 1;
            end else begin
               m_cnt = (m_cnt + 1 > MAXV) ? MAXV : m_cnt + 1;
            end
         end else if (m_tick) begin
            m_open = 1; m_cnt = 0; open_cyc = cyc;
         end
         m_irq_pre = m_irq;
         if (m_done) begin
            m_sum = (m_acc + m_res > MAXV) ? MAXV : m_acc + m_res;
            if (m_mc + 1 >= (1 << meas_sel)) begin
               if (!m_irq_pre) begin
                  m_sh = m_sum; m_irq = 1; m_bits = 0;
               end
               m_acc = 0; m_mc = 0;
            end else begin
               m_acc = m_sum; m_mc++;
            end
         end
         if (m_irq_pre && m_sev) begin
            m_sh = (m_sh << 1) & MAXV;
            m_bits++;
            if (m_bits == CW) m_irq = 0;
         end
         rq2 = rq1; rq1 = rq0; rq0 = ref_in;
         sq2 = sq1; sq1 = sq0; sq0 = sclk;
      end
   end

   // Compare against the reference on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         check(irq === m_irq, "R6 irq vs reference", int'(irq), int'(m_irq));
         check(sdo === m_sh[CW-1], "R8 sdo vs reference", int'(sdo), m_sh[CW-1]);
      end
   end

   task automatic do_reset(input logic rate, input logic [1:0] msel);
      @(negedge clk);
      rst_n = 1'b0; ref_in = 1'b0; sclk = 1'b0;
      rate_sel = rate; meas_sel = msel;
      repeat (2) @(negedge clk);
      check(irq === 1'b0, "R1 irq in reset", int'(irq), 0);
      check(sdo === 1'b0, "R1 sdo in reset", int'(sdo), 0);
      rst_n = 1'b1;
   endtask

   // Reference event lands on edge e (driven after edge e-3)
   task automatic ref_at(input int e);
      while (cyc < e - 3) @(negedge clk);
      ref_in = 1'b1;
      repeat (4) @(negedge clk);
      ref_in = 1'b0;
   endtask

   task automatic measure(input int d, output int expv);
      int target;
      while (!m_open) @(negedge clk);
      target = (cyc + 3 > open_cyc + d) ? cyc + 3 : open_cyc + d;
      expv = target - open_cyc;
      ref_at(target);
   endtask

   task automatic wait_irq();
      while (irq !== 1'b1) @(negedge clk);
   endtask

   task automatic read_word(output int v);
      v = 0;
      for (int i = 0; i < CW; i++) begin
         @(negedge clk);
         check(irq === 1'b1, "R8 irq held during readout", int'(irq), 1);
         v = (v << 1) | int'(sdo);
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
         repeat (3) @(negedge clk);
      end
      @(negedge clk);
      check(irq === 1'b0, "R8 irq low after last bit", int'(irq), 0);
      check(sdo === 1'b0, "R8 sdo zero after last bit", int'(sdo), 0);
   endtask

   initial begin
      int v, e1, e2, e3, e4;
      repeat (3) @(negedge clk);

      // R4: early reference edge ignored, window 40..55
      do_reset(1'b0, 2'd0);
      ref_at(20);
      ref_at(55);
      wait_irq();
      read_word(v);
      check(v == 15, "R4 idle reference ignored, result", v, 15);

      // R2: fast rate, first tick at edge 80
      do_reset(1'b1, 2'd0);
      ref_at(100);
      wait_irq();
      read_word(v);
      check(v == 20, "R2 fast prescale result", v, 20);

      // R3: window spans the tick at edge 80
      do_reset(1'b0, 2'd0);
      ref_at(90);
      wait_irq();
      read_word(v);
      check(v == 50, "R3 tick inside window ignored", v, 50);

      // R6: four-result batch
      do_reset(1'b0, 2'd2);
      measure(5, e1); measure(6, e2); measure(7, e3);
      check(irq === 1'b0, "R6 no irq before batch end", int'(irq), 0);
      measure(8, e4);
      wait_irq();
      read_word(v);
      check(v == e1 + e2 + e3 + e4, "R6 batch of four sum", v, e1 + e2 + e3 + e4);

      // R6: two-result batch
      meas_sel = 2'd1;
      measure(30, e1); measure(33, e2);
      wait_irq();
      read_word(v);
      check(v == e1 + e2, "R6 batch of two sum", v, e1 + e2);

      // R7: second batch while unread is dropped
      do_reset(1'b0, 2'd0);
      measure(9, e1);
      wait_irq();
      measure(12, e2);
      repeat (5) @(negedge clk);
      read_word(v);
      check(v == e1, "R7 pending word kept", v, e1);
      measure(14, e3);
      wait_irq();
      read_word(v);
      check(v == e3, "R7 next batch after readout", v, e3);

      // R9: stray serial clocks while idle
      for (int k = 0; k < 5; k++) begin
         sclk = 1'b1; repeat (4) @(negedge clk);
         sclk = 1'b0; repeat (4) @(negedge clk);
         check(sdo === 1'b0 && irq === 1'b0, "R9 idle serial clock no effect",
               int'({irq, sdo}), 0);
      end
      measure(11, e1);
      wait_irq();
      read_word(v);
      check(v == e1, "R9 readout whole after stray clocks", v, e1);

      // R5: missing reference saturates window and sum
      do_reset(1'b0, 2'd1);
      ref_at(40 + 66000);
      measure(10, e1);
      wait_irq();
      read_word(v);
      check(v == MAXV, "R5 saturated result", v, MAXV);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule